// File: doc/BRIEF.md
# Dual Frame FIFO with Wrapped Occupancy Field

This block sits between a register interface and a serial bus engine and holds two independent frame queues, each eight entries deep and nine bits wide. The transmit queue is filled from the register side and drained by the engine. The receive queue is filled by the engine and drained from the register side. Both queues keep first-in, first-out order, and a read pops its word into a registered data output.

Each queue reports its occupancy through a three-bit level field. Eight entries do not fit in that field, so it wraps to zero when a queue is full, and a separate full flag tells a full queue from an empty one. Each queue also raises a half flag from four entries upward. A soft-reset pulse empties both queues at once. If the receive queue still held data at that pulse, a sticky bus-busy error flag is raised. It stays set until a later soft-reset pulse finds the receive queue empty.

Top module: `frame_fifo_pair`

## Requirements
- R1: Each queue stores up to 8 words of 9 bits.
- R2: The level field of a queue equals its entry count modulo 8, so it reads 0 for both 0 and 8 entries.
- R3: `rx_full` is 1 exactly when the receive queue holds 8 entries, and `rx_level` then reads 0.
- R4: `tx_full` is 1 exactly when the transmit queue holds 8 entries.
- R5: `tx_half` and `rx_half` are 1 exactly when their queue holds 4 or more entries.
- R6: Words are popped in the order they were pushed. A pop loads the word into the read-data output at the clock edge where the pop is sampled.
- R7: A push to a full queue is dropped. Occupancy and stored words are unchanged.
- R8: A pop from an empty queue leaves occupancy at 0 and loads 0 into the read-data output.
- R9: A `soft_rst` pulse empties both queues and clears both read-data outputs in the next cycle.
- R10: A `soft_rst` pulse sets `busy_err` if the receive queue is not empty at that edge and clears it otherwise. Between pulses, `busy_err` holds its value.
- R11: A push and a pop to the same queue in one cycle are both accepted when the queue is neither empty nor full, leaving occupancy unchanged. On a full queue, only the pop is accepted.
- R12: `soft_rst` takes priority over a push or pop in the same cycle, and that push or pop has no effect.
- R13: After `rst_n` is released, both queues are empty, all flags are 0 and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush pulse for both queues |
| tx_push | input | 1 | Register-side write into transmit queue |
| tx_wdata | input | 9 | Word to write into transmit queue |
| tx_pop | input | 1 | Engine-side read from transmit queue |
| tx_rdata | output | 9 | Last word popped from transmit queue |
| tx_level | output | 3 | Transmit occupancy modulo 8 |
| tx_full | output | 1 | Transmit queue holds 8 entries |
| tx_half | output | 1 | Transmit queue holds 4 or more entries |
| rx_push | input | 1 | Engine-side write into receive queue |
| rx_wdata | input | 9 | Word to write into receive queue |
| rx_pop | input | 1 | Register-side read from receive queue |
| rx_rdata | output | 9 | Last word popped from receive queue |
| rx_level | output | 3 | Receive occupancy modulo 8 |
| rx_full | output | 1 | Receive queue holds 8 entries |
| rx_half | output | 1 | Receive queue holds 4 or more entries |
| busy_err | output | 1 | Receive queue was not empty at the last soft reset |

## Verification
Every result of this block is due one clock edge after its stimulus. This covers the level fields and flags after a push, pop or flush, the read data after a pop, and `busy_err` after a soft-reset pulse. The bench drives inputs on the falling edge and samples shortly after the next rising edge, so each check sees exactly the edge that consumed its stimulus. The scoreboard queues each expected read word at the moment its pop is driven. The monitor compares that word in the cycle after the edge, and the status fields are compared against the model occupancy in the same window.

// File: rtl/ffp_pkg.sv
package ffp_pkg;
  localparam int unsigned FRAME_W   = 9;
  localparam int unsigned Q_DEPTH   = 8;
  localparam int unsigned LEVEL_W   = 3;

  typedef struct packed {
    logic full;
    logic half;
    logic empty;
  } occ_flags_t;
endpackage

// File: rtl/ffp_queue.sv
module ffp_queue #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] rdata_q, rdata_d;
  logic             push_ok, pop_ok, rdata_en;
  logic [DEPTH-1:0] wr_en;

  assign push_ok  = push && (cnt_q != CNT_MAX) && !flush;
  assign pop_ok   = pop && (cnt_q != '0) && !flush;
  assign rdata_en = flush || pop;

  always_comb begin
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    if (flush) begin
      wr_d    = '0;
      rd_d    = '0;
      cnt_d   = '0;
      rdata_d = '0;
    end else begin
      if (push_ok) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok) begin
        rd_d    = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
        rdata_d = mem[rd_q];
      end else if (pop) begin
        rdata_d = '0;
      end
      cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign wr_en[i] = push_ok && (wr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en[i]) mem[i] <= wdata;
    end
  end

  assign rdata = rdata_q;
  assign count = cnt_q;
endmodule

// File: rtl/ffp_occ.sv
module ffp_occ
  import ffp_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned LEVEL_W = 3,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]   count,
  output logic [LEVEL_W-1:0] level,
  output occ_flags_t         flags
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);

  // the field keeps only the low bits, so a full queue wraps to zero
  assign level       = count[LEVEL_W-1:0];
  assign flags.full  = (count == CNT_MAX);
  assign flags.half  = (count >= CNT_HALF);
  assign flags.empty = (count == '0);
endmodule

// File: rtl/frame_fifo_pair.sv
module frame_fifo_pair
  import ffp_pkg::*;
#(
  parameter int unsigned WIDTH   = FRAME_W,
  parameter int unsigned DEPTH   = Q_DEPTH,
  parameter int unsigned LVL_W   = LEVEL_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_full,
  output logic             tx_half,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_full,
  output logic             rx_half,
  output logic             busy_err
);
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  occ_flags_t       tx_flg, rx_flg;
  logic             busy_q, busy_d;

  ffp_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .count(tx_cnt)
  );

  ffp_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .count(rx_cnt)
  );

  ffp_occ #(.DEPTH(DEPTH), .LEVEL_W(LVL_W)) u_txocc (
    .count(tx_cnt), .level(tx_level), .flags(tx_flg)
  );

  ffp_occ #(.DEPTH(DEPTH), .LEVEL_W(LVL_W)) u_rxocc (
    .count(rx_cnt), .level(rx_level), .flags(rx_flg)
  );

  always_comb begin
    busy_d = busy_q;
    if (soft_rst) busy_d = !rx_flg.empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign tx_full  = tx_flg.full;
  assign tx_half  = tx_flg.half;
  assign rx_full  = rx_flg.full;
  assign rx_half  = rx_flg.half;
  assign busy_err = busy_q;
endmodule

// File: rtl/ffp_checker.sv
module ffp_checker #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             tx_push,
  input logic             tx_pop,
  input logic [LVL_W-1:0] tx_level,
  input logic             tx_full,
  input logic             tx_half,
  input logic             rx_push,
  input logic             rx_pop,
  input logic [WIDTH-1:0] rx_rdata,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_full,
  input logic             rx_half,
  input logic             busy_err
);
  a_r3_full_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> (rx_level == '0));

  a_r5_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full |-> tx_half) and (rx_full |-> rx_half));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !tx_pop && !soft_rst) |=> tx_full);

  a_r8_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_full && rx_level == '0 && rx_pop && !rx_push && !soft_rst)
      |=> (rx_rdata == '0 && rx_level == '0 && !rx_full));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_level == '0 && !tx_full && rx_level == '0 && !rx_full));

  a_r10_busy_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && (rx_level != '0 || rx_full)) |=> busy_err);

  a_r11_level_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_pop && !soft_rst && tx_level != '0 && !tx_full)
      |=> ($stable(tx_level) && !tx_full));
endmodule

bind frame_fifo_pair ffp_checker #(.WIDTH(WIDTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/frame_fifo_pair_bench.sv
module frame_fifo_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [8:0] tx_wdata = '0, rx_wdata = '0;
  logic [8:0] tx_rdata, rx_rdata;
  logic [2:0] tx_level, rx_level;
  logic       tx_full, tx_half, rx_full, rx_half, busy_err;

  int n_chk = 0, n_fail = 0;
  logic [8:0] tx_q[$], rx_q[$];
  logic [8:0] exp_tx[$], exp_rx[$];
  logic       tx_pend = 1'b0, rx_pend = 1'b0;
  logic       exp_busy = 1'b0;

  always #2 clk = ~clk;

  frame_fifo_pair u_frame_fifo_pair (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_level(tx_level), .tx_full(tx_full), .tx_half(tx_half),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_level(rx_level), .rx_full(rx_full), .rx_half(rx_half),
    .busy_err(busy_err)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares popped words one edge after the pop
  always @(posedge clk) begin
    #1;
    if (tx_pend && exp_tx.size() > 0) chk("R6 tx read data", tx_rdata, exp_tx.pop_front());
    if (rx_pend && exp_rx.size() > 0) chk("R6 rx read data", rx_rdata, exp_rx.pop_front());
  end

  task automatic status(input string ctx);
    int ts = tx_q.size();
    int rs = rx_q.size();
    chk({"R2 tx level ", ctx}, 9'(tx_level), 9'(ts % 8));
    chk({"R2 rx level ", ctx}, 9'(rx_level), 9'(rs % 8));
    chk({"R4 tx full ", ctx},  9'(tx_full),  9'(ts == 8));
    chk({"R3 rx full ", ctx},  9'(rx_full),  9'(rs == 8));
    chk({"R5 tx half ", ctx},  9'(tx_half),  9'(ts >= 4));
    chk({"R5 rx half ", ctx},  9'(rx_half),  9'(rs >= 4));
    chk({"R10 busy ", ctx},    9'(busy_err), 9'(exp_busy));
  endtask

  // driver: applies one cycle of stimulus and updates the model
  task automatic cyc(input logic tp, input logic [8:0] td, input logic tpo,
                     input logic rp, input logic [8:0] rd, input logic rpo,
                     input logic sr, input string ctx);
    @(negedge clk);
    tx_push = tp; tx_wdata = td; tx_pop = tpo;
    rx_push = rp; rx_wdata = rd; rx_pop = rpo;
    soft_rst = sr;
    tx_pend = tpo || sr;
    rx_pend = rpo || sr;
    if (sr) begin
      exp_busy = (rx_q.size() != 0);
      tx_q.delete(); rx_q.delete();
      exp_tx.push_back(9'h0); exp_rx.push_back(9'h0);
    end else begin
      int ts = tx_q.size();
      int rs = rx_q.size();
      if (tpo) exp_tx.push_back(ts > 0 ? tx_q.pop_front() : 9'h0);
      if (rpo) exp_rx.push_back(rs > 0 ? rx_q.pop_front() : 9'h0);
      if (tp && ts < 8) tx_q.push_back(td);
      if (rp && rs < 8) rx_q.push_back(rd);
    end
    @(posedge clk); #1;
    status(ctx);
  endtask

  task automatic idle();
    cyc(0, 9'h0, 0, 0, 9'h0, 0, 0, "idle");
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R13: reset state
    chk("R13 tx_rdata", tx_rdata, 9'h0);
    chk("R13 rx_rdata", rx_rdata, 9'h0);
    status("R13 reset");
    @(negedge clk); rst_n = 1'b1;
    idle();

    // R1 R2 R4 R5: fill transmit queue to capacity
    for (int i = 0; i < 8; i++) cyc(1, 9'(9'h1A0 + i), 0, 0, 9'h0, 0, 0, "R1 tx fill");
    // R7: ninth push dropped
    cyc(1, 9'h0FF, 0, 0, 9'h0, 0, 0, "R7 push on full");
    // R6: drain in order, ninth word must not appear
    for (int i = 0; i < 8; i++) cyc(0, 9'h0, 1, 0, 9'h0, 0, 0, "R6 tx drain");
    // R8: pop on empty returns zero
    cyc(0, 9'h0, 1, 0, 9'h0, 0, 0, "R8 empty pop");
    idle();

    // R3: receive queue full reads level 0
    for (int i = 0; i < 8; i++) cyc(0, 9'h0, 0, 1, 9'(9'h055 + 3 * i), 0, 0, "R3 rx fill");
    // R11: push+pop on full queue: pop only
    cyc(0, 9'h0, 0, 1, 9'h1FF, 1, 0, "R11 full push+pop");
    // R11: push+pop on partial queue: level stable
    cyc(0, 9'h0, 0, 1, 9'h123, 1, 0, "R11 partial push+pop");
    cyc(1, 9'h011, 0, 0, 9'h0, 0, 0, "R11 tx one");
    cyc(1, 9'h022, 1, 0, 9'h0, 0, 0, "R11 tx push+pop");

    // R9 R10: soft reset with receive data sets busy and flushes
    cyc(0, 9'h0, 0, 0, 9'h0, 0, 1, "R9 R10 flush nonempty");
    cyc(0, 9'h0, 1, 0, 9'h0, 1, 0, "R9 pops after flush");
    // R10: flush with empty receive clears busy
    cyc(0, 9'h0, 0, 0, 9'h0, 0, 1, "R10 flush empty");
    // R12: flush wins over pushes in the same cycle
    cyc(0, 9'h0, 0, 1, 9'h077, 0, 0, "R12 preload");
    cyc(1, 9'h033, 0, 1, 9'h044, 1, 1, "R12 flush with traffic");
    cyc(0, 9'h0, 1, 0, 9'h0, 1, 0, "R12 verify empty");
    idle();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule